// File: doc/BRIEF.md
# Row and Column Redundancy Remapper

This block sits in the access path of a memory sub-array that carries spare rows and spare columns. After reset it takes in its repair entries one bit at a time from a serial fuse shadow chain. Each entry is a valid bit followed by the address of a defective row or column. The block reports not-ready until the whole chain has been received, and it ignores the chain from then on.

Once ready, every access is matched against the entries without any clock delay. A row address that equals a valid row entry turns off the normal row and drives the select of the matching spare row. A column address that equals a valid column entry steers the read data mux from the normal bit-line to the matching spare bit-line. Entries without the valid bit never take part in a match. When several entries hold the same address, the lowest-numbered one is used and a multi-hit flag is raised.

Top module: `redundancy_remap`

## Requirements
- R1: After reset, `rdy` is 0, and `norm_row_en`, `spare_row_sel`, `spare_col_sel` and `rd_bit` are all 0. `rdy` becomes 1 right after the clock edge that captures the last of the TOTAL = N_SPARE_ROW*(1+ROW_W) + N_SPARE_COL*(1+COL_W) chain bits, which are counted only on edges where `fuse_vld` is 1. `rdy` then stays 1 until the next reset.
- R2: The chain bits arrive in this order: row entry 0 to row entry N_SPARE_ROW-1, then column entry 0 to column entry N_SPARE_COL-1. Each entry sends its valid bit first, then its address from MSB to LSB.
- R3: When ready and `acc_row` equals the address of a valid row entry i, `spare_row_sel` has only bit i set and `norm_row_en` is 0.
- R4: An entry whose valid bit is 0 never matches, including when its address field is all zeros.
- R5: When two or more valid row entries match, `spare_row_sel` selects the lowest index and `row_multi_hit` is 1. Otherwise `row_multi_hit` is 0.
- R6: When ready and no valid row entry matches, `norm_row_en` is 1 and `spare_row_sel` is 0.
- R7: When ready and `acc_col` equals the address of a valid column entry j, `spare_col_sel` has only bit j set and `rd_bit` equals `rd_spare[j]`.
- R8: When ready and no valid column entry matches, `spare_col_sel` is 0 and `rd_bit` equals `rd_norm`.
- R9: When two or more valid column entries match, the lowest index is selected and `col_multi_hit` is 1. Otherwise `col_multi_hit` is 0.
- R10: All select, flag and data outputs follow `acc_row`, `acc_col`, `rd_norm` and `rd_spare` within the same cycle.
- R11: Chain bits offered after `rdy` is 1 have no effect on any later match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fuse_bit | input | 1 | Serial data from the fuse shadow chain |
| fuse_vld | input | 1 | Qualifies `fuse_bit` on this edge |
| rdy | output | 1 | Repair entries loaded; accesses allowed |
| acc_row | input | ROW_W | Logical row address of the access |
| acc_col | input | COL_W | Logical column address of the access |
| norm_row_en | output | 1 | Enable for the normal row decode |
| spare_row_sel | output | N_SPARE_ROW | One-hot spare row select |
| row_multi_hit | output | 1 | More than one row entry matched |
| spare_col_sel | output | N_SPARE_COL | One-hot spare column select |
| col_multi_hit | output | 1 | More than one column entry matched |
| rd_norm | input | 1 | Read bit from the addressed normal column |
| rd_spare | input | N_SPARE_COL | Read bits from the spare columns |
| rd_bit | output | 1 | Read bit after column steering |

## Verification
Two repair maps are loaded, and every row address is swept under each of them, with the column address and the read data bits changing on every access. The first map holds a mix of entries. Some are valid and some are not, including an invalid entry whose address is zero next to a valid entry that also has address zero. It also has duplicate row and column addresses. This map separates a true hit from a blocked entry, and lowest-index priority from any other choice. The second map places its only valid entries in the highest slots with all-zero addresses. A fault in how the chain is sliced into entries, or in the bit order, then shows up as a wrong or missing select. Garbage chain bits are driven during the first sweep, and loading pauses part-way through, so a loader that miscounts or keeps shifting after it is ready is exposed.

// File: rtl/remap_pkg.sv
// Package shared by the redundancy remapper.
// Holds the state type of the fuse chain loader.
package remap_pkg;
    typedef enum logic {
        LD_FILL = 1'b0,
        LD_DONE = 1'b1
    } ld_state_t;
endpackage

// File: rtl/remap_fuse_loader.sv
// Serial fuse shadow chain receiver.
// It shifts TOTAL qualified bits into a register. The first bit received
// ends up in the MSB. It then locks and raises done.
// Assumes the fuse source presents each bit for one qualified edge.
module remap_fuse_loader #(
    parameter int TOTAL = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fuse_bit,
    input  logic             fuse_vld,
    output logic [TOTAL-1:0] chain,
    output logic             done
);
    import remap_pkg::*;

    localparam int CW = (TOTAL > 1) ? $clog2(TOTAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

    ld_state_t      state;
    logic [CW-1:0]  cnt;

    // Shift in qualified bits until the last one is captured, then freeze.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LD_FILL;
            cnt   <= '0;
            chain <= '0;
        end else if (state == LD_FILL && fuse_vld) begin
            chain <= {chain[TOTAL-2:0], fuse_bit};
            cnt   <= cnt + 1'b1;
            if (cnt == LAST) state <= LD_DONE;
        end
    end

    assign done = (state == LD_DONE);
endmodule

// File: rtl/remap_match.sv
// Address matcher for one bank of repair entries.
// It compares the key against every valid entry. It returns a one-hot
// select of the lowest matching entry and a flag for more than one match.
// Everything is forced to zero while en is low.
module remap_match #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic               en,
    input  logic [W-1:0]       key,
    input  logic [N-1:0][W-1:0] ent_addr,
    input  logic [N-1:0]       ent_vld,
    output logic [N-1:0]       sel,
    output logic               multi
);
    logic [N-1:0] hit;

    // One comparator per entry, gated by that entry's valid bit.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = en && ent_vld[g] && (ent_addr[g] == key);
    end

    // Keep the lowest set bit; flag when clearing it leaves any bit set.
    always_comb begin
        sel   = hit & (~hit + N'(1));
        multi = (hit & (hit - N'(1))) != '0;
    end
endmodule

// File: rtl/remap_colmux.sv
// Read data steering for column repair.
// It passes the selected spare bit-line when a spare column is chosen,
// otherwise the normal bit-line, and 0 while not enabled.
// Assumes sel is one-hot or zero.
module remap_colmux #(
    parameter int N = 4
) (
    input  logic         en,
    input  logic [N-1:0] sel,
    input  logic         rd_norm,
    input  logic [N-1:0] rd_spare,
    output logic         rd_bit
);
    // Choose the data source for this access.
    always_comb begin
        if (!en)            rd_bit = 1'b0;
        else if (|sel)      rd_bit = |(sel & rd_spare);
        else                rd_bit = rd_norm;
    end
endmodule

// File: rtl/redundancy_remap.sv
// Row and column redundancy remapper.
// It loads the repair entries from the serial fuse chain after reset and
// slices the chain into row and column entries (valid bit, then the address
// MSB first). It then remaps each access combinationally.
// Assumes the fuse chain holds exactly TOTAL bits.
module redundancy_remap #(
    parameter int ROW_W       = 8,
    parameter int COL_W       = 5,
    parameter int N_SPARE_ROW = 8,
    parameter int N_SPARE_COL = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fuse_bit,
    input  logic                   fuse_vld,
    output logic                   rdy,
    input  logic [ROW_W-1:0]       acc_row,
    input  logic [COL_W-1:0]       acc_col,
    output logic                   norm_row_en,
    output logic [N_SPARE_ROW-1:0] spare_row_sel,
    output logic                   row_multi_hit,
    output logic [N_SPARE_COL-1:0] spare_col_sel,
    output logic                   col_multi_hit,
    input  logic                   rd_norm,
    input  logic [N_SPARE_COL-1:0] rd_spare,
    output logic                   rd_bit
);
    localparam int RE_W     = 1 + ROW_W;
    localparam int CE_W     = 1 + COL_W;
    localparam int ROW_BITS = N_SPARE_ROW * RE_W;
    localparam int TOTAL    = ROW_BITS + N_SPARE_COL * CE_W;

    logic [TOTAL-1:0]                   chain;
    logic [N_SPARE_ROW-1:0][ROW_W-1:0]  row_addr;
    logic [N_SPARE_ROW-1:0]             row_vld;
    logic [N_SPARE_COL-1:0][COL_W-1:0]  col_addr;
    logic [N_SPARE_COL-1:0]             col_vld;

    remap_fuse_loader #(.TOTAL(TOTAL)) u_ldr (
        .clk      (clk),
        .rst_n    (rst_n),
        .fuse_bit (fuse_bit),
        .fuse_vld (fuse_vld),
        .chain    (chain),
        .done     (rdy)
    );

    // Row entries sit first in the chain, entry 0 at the top.
    for (genvar g = 0; g < N_SPARE_ROW; g++) begin : g_row
        localparam int HI = TOTAL - 1 - g * RE_W;
        assign row_vld[g]  = chain[HI];
        assign row_addr[g] = chain[HI-1 -: ROW_W];
    end

    // Column entries follow the row entries.
    for (genvar g = 0; g < N_SPARE_COL; g++) begin : g_col
        localparam int HI = TOTAL - 1 - ROW_BITS - g * CE_W;
        assign col_vld[g]  = chain[HI];
        assign col_addr[g] = chain[HI-1 -: COL_W];
    end

    remap_match #(.N(N_SPARE_ROW), .W(ROW_W)) u_row (
        .en       (rdy),
        .key      (acc_row),
        .ent_addr (row_addr),
        .ent_vld  (row_vld),
        .sel      (spare_row_sel),
        .multi    (row_multi_hit)
    );

    remap_match #(.N(N_SPARE_COL), .W(COL_W)) u_col (
        .en       (rdy),
        .key      (acc_col),
        .ent_addr (col_addr),
        .ent_vld  (col_vld),
        .sel      (spare_col_sel),
        .multi    (col_multi_hit)
    );

    remap_colmux #(.N(N_SPARE_COL)) u_mux (
        .en       (rdy),
        .sel      (spare_col_sel),
        .rd_norm  (rd_norm),
        .rd_spare (rd_spare),
        .rd_bit   (rd_bit)
    );

    // The normal row is used only when ready and no spare row is taken.
    assign norm_row_en = rdy && (spare_row_sel == '0);
endmodule

// File: rtl/remap_chk.sv
// Property checker for redundancy_remap, attached by bind.
// It relates the port-level outputs to one another and over time.
module remap_chk #(
    parameter int ROW_W       = 8,
    parameter int COL_W       = 5,
    parameter int N_SPARE_ROW = 8,
    parameter int N_SPARE_COL = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rdy,
    input logic                   norm_row_en,
    input logic [N_SPARE_ROW-1:0] spare_row_sel,
    input logic                   row_multi_hit,
    input logic [N_SPARE_COL-1:0] spare_col_sel,
    input logic                   col_multi_hit,
    input logic                   rd_norm,
    input logic [N_SPARE_COL-1:0] rd_spare,
    input logic                   rd_bit
);
    // R1
    idle_when_loading_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> (spare_row_sel == '0 && spare_col_sel == '0 && !norm_row_en && !rd_bit));

    // R1
    rdy_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> rdy);

    // R3
    row_path_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> (norm_row_en != (|spare_row_sel)));

    // R5
    row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(spare_row_sel));

    // R5
    row_multi_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_multi_hit |-> (spare_row_sel != '0));

    // R9
    col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(spare_col_sel) && (!col_multi_hit || spare_col_sel != '0));

    // R7
    col_spare_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spare_col_sel != '0) |-> (rd_bit == |(spare_col_sel & rd_spare)));

    // R8
    col_norm_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && spare_col_sel == '0) |-> (rd_bit == rd_norm));
endmodule

bind redundancy_remap remap_chk #(
    .ROW_W(ROW_W), .COL_W(COL_W),
    .N_SPARE_ROW(N_SPARE_ROW), .N_SPARE_COL(N_SPARE_COL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rdy(rdy), .norm_row_en(norm_row_en),
    .spare_row_sel(spare_row_sel), .row_multi_hit(row_multi_hit),
    .spare_col_sel(spare_col_sel), .col_multi_hit(col_multi_hit),
    .rd_norm(rd_norm), .rd_spare(rd_spare), .rd_bit(rd_bit)
);

// File: tb/tb_redundancy_remap.sv
`timescale 1ns/1ps
module tb_redundancy_remap;
    localparam int RW = 8, CW = 5, NR = 8, NC = 4;
    localparam int TOTAL = NR * (1 + RW) + NC * (1 + CW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fuse_bit = 1'b0, fuse_vld = 1'b0;
    logic [RW-1:0] acc_row = '0;
    logic [CW-1:0] acc_col = '0;
    logic rd_norm = 1'b0;
    logic [NC-1:0] rd_spare = '0;
    logic rdy, norm_row_en, row_multi_hit, col_multi_hit, rd_bit;
    logic [NR-1:0] spare_row_sel;
    logic [NC-1:0] spare_col_sel;

    always #2.5 clk = ~clk;

    redundancy_remap #(.ROW_W(RW), .COL_W(CW), .N_SPARE_ROW(NR), .N_SPARE_COL(NC)) dut (
        .clk(clk), .rst_n(rst_n), .fuse_bit(fuse_bit), .fuse_vld(fuse_vld), .rdy(rdy),
        .acc_row(acc_row), .acc_col(acc_col), .norm_row_en(norm_row_en),
        .spare_row_sel(spare_row_sel), .row_multi_hit(row_multi_hit),
        .spare_col_sel(spare_col_sel), .col_multi_hit(col_multi_hit),
        .rd_norm(rd_norm), .rd_spare(rd_spare), .rd_bit(rd_bit)
    );

    // Reference model state
    int rv[NR], ra[NR], cv[NC], ca[NC];
    int model_cnt = 0;
    bit started = 0, finished = 0;
    int n_cmp = 0, n_bad = 0;

    // Model of the loader: counts qualified bits, saturating at TOTAL (R11)
    always @(posedge clk) begin
        if (!rst_n) model_cnt <= 0;
        else if (fuse_vld && model_cnt < TOTAL) model_cnt <= model_cnt + 1;
    end

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h (row=%0h col=%0h)",
                     req, what, act, exp, acc_row, acc_col);
        end
    endtask

    // Compare every cycle, away from the edge; outputs follow inputs in the same cycle (R10)
    always @(negedge clk) begin
        if (started && !finished) begin
            bit ready;
            int rfirst, rcount, cfirst, ccount, exp_rs, exp_cs, exp_rd;
            bit blocked;
            string rreq, creq;
            ready = (model_cnt >= TOTAL);
            rfirst = -1; rcount = 0; cfirst = -1; ccount = 0; blocked = 0;
            for (int i = NR - 1; i >= 0; i--) begin
                if (ra[i] == int'(acc_row)) begin
                    if (rv[i] != 0) begin rfirst = i; rcount++; end
                    else blocked = 1;
                end
            end
            for (int j = NC - 1; j >= 0; j--) begin
                if (ca[j] == int'(acc_col)) begin
                    if (cv[j] != 0) begin cfirst = j; ccount++; end
                    else blocked = 1;
                end
            end
            if (!ready) begin rfirst = -1; rcount = 0; cfirst = -1; ccount = 0; end
            exp_rs = (rfirst >= 0) ? (1 << rfirst) : 0;
            exp_cs = (cfirst >= 0) ? (1 << cfirst) : 0;
            exp_rd = !ready ? 0 : (cfirst >= 0) ? int'(rd_spare[cfirst]) : int'(rd_norm);
            rreq = !ready ? "R1" : (rcount > 1) ? "R5" : blocked ? "R4" : (rcount == 1) ? "R3" : "R6";
            creq = !ready ? "R1" : (ccount > 1) ? "R9" : blocked ? "R4" : (ccount == 1) ? "R7" : "R8";
            chk(fuse_vld && ready ? "R11" : "R1", "rdy", int'(rdy), int'(ready));
            chk(rreq, "norm_row_en", int'(norm_row_en), (ready && rfirst < 0) ? 1 : 0);
            chk(rreq, "spare_row_sel", int'(spare_row_sel), exp_rs);
            chk(rreq, "row_multi_hit", int'(row_multi_hit), (rcount > 1) ? 1 : 0);
            chk(creq, "spare_col_sel", int'(spare_col_sel), exp_cs);
            chk(creq, "col_multi_hit", int'(col_multi_hit), (ccount > 1) ? 1 : 0);
            chk(creq, "rd_bit", int'(rd_bit), exp_rd);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic send_bit(bit b, int k);
        if (k % 7 == 3) begin fuse_vld = 1'b0; acc_row = RW'(k); tick(); end
        fuse_bit = b; fuse_vld = 1'b1; acc_row = RW'(k * 13); acc_col = CW'(k);
        tick();
    endtask

    // Chain order (R2): row entries then column entries, valid bit first, address MSB first
    task automatic load_chain();
        int k = 0;
        for (int i = 0; i < NR; i++) begin
            send_bit(rv[i] != 0, k++);
            for (int b = RW - 1; b >= 0; b--) send_bit(ra[i][b], k++);
        end
        for (int j = 0; j < NC; j++) begin
            send_bit(cv[j] != 0, k++);
            for (int b = CW - 1; b >= 0; b--) send_bit(ca[j][b], k++);
        end
        fuse_vld = 1'b0;
        tick();
    endtask

    task automatic sweep(bit garbage);
        for (int r = 0; r < (1 << RW); r++) begin
            acc_row = RW'(r);
            acc_col = CW'(r * 3);
            rd_norm = ~r[0];
            rd_spare = NC'(r ^ (r >> 4));
            fuse_vld = garbage;          // R11: extra chain bits after ready
            fuse_bit = garbage ? 1'($urandom) : 1'b0;
            tick();
        end
        fuse_vld = 1'b0;
    endtask

    initial begin
        #(20000 * 5);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // Map A: mixed valid/invalid, zero address blocked, duplicates
        ra = '{8'h12, 8'h00, 8'h40, 8'h12, 8'hFF, 8'h33, 8'h00, 8'h7E};
        rv = '{1, 0, 1, 1, 1, 0, 1, 1};
        ca = '{5'h03, 5'h00, 5'h1F, 5'h03};
        cv = '{1, 0, 1, 1};
        tick(); tick();
        started = 1;
        tick();
        rst_n = 1'b1;
        load_chain();
        sweep(1'b1);
        // Map B: only the highest slots valid, all-zero addresses
        rst_n = 1'b0;
        tick(); tick();
        ra = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        rv = '{0, 0, 0, 0, 0, 0, 0, 1};
        ca = '{5'h00, 5'h00, 5'h00, 5'h00};
        cv = '{0, 0, 0, 1};
        rst_n = 1'b1;
        load_chain();
        sweep(1'b0);
        tick();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule